// File: doc/BRIEF.md
# Sector Write-Protect Guard

This block screens every write-type request to a 128 KiB serial flash array (four 32 KiB sectors, 512 pages of 256 bytes) against a two-bit protect level. Each cycle it takes a command code, a 17-bit byte address, a data byte and the current protect level. One clock later it answers with either a grant pulse or a reject pulse. On a grant it also reports the sector, and for programs the page, that the operation touches.

As the protect level rises, the locked region grows downward from the top of memory. Erasing the whole chip is only permitted when nothing at all is locked.

The block also carries a small behavioural cell array so that a bench can observe how program and erase change the stored bits. Programming can only turn ones into zeros. Erasing restores ones across a whole sector or the whole array. The model keeps the lowest 2^MODEL_OFS_W byte offsets of each sector, and higher offset bits alias onto them. It is read through a combinational read port.

Top module: `flash_wguard`

## Requirements
- R1: After reset, `grant` and `reject` are low, `hit_sector` and `hit_page` are zero, and every modelled byte reads 8'hFF.
- R2: Command codes are 2'b00 idle, 2'b01 program byte, 2'b10 sector erase and 2'b11 chip erase. With protect level 2'b00, program and sector erase are granted in every sector.
- R3: With protect level 2'b01, only sector 3 is locked, and sectors 0 to 2 remain writable.
- R4: With protect level 2'b10, sectors 2 and 3 are locked, and sectors 0 and 1 remain writable.
- R5: With protect level 2'b11, every program, sector erase and chip erase is rejected.
- R6: Chip erase is granted only when the protect level is 2'b00, and is rejected otherwise.
- R7: The sector is address bits 16:15 and the page is address bits 16:8. One cycle after a granted program, `hit_sector` and `hit_page` carry those fields. After a granted sector erase, `hit_sector` carries the sector and `hit_page` is zero. In every other cycle both are zero.
- R8: A granted program stores the old byte ANDed with the new data. A bit that is already 0 is never set again by a program.
- R9: A granted sector erase sets every modelled byte of that sector to 8'hFF and leaves the other sectors untouched. A granted chip erase sets every modelled byte to 8'hFF.
- R10: A locked request leaves the array unchanged and raises `reject` for exactly one cycle. `grant` and `reject` are never high together.
- R11: A request with `req_valid` low, or with the idle command, produces neither grant nor reject and changes no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_cmd | input | 2 | Command code (R2) |
| req_addr | input | 17 | Byte address |
| req_data | input | 8 | Data byte for program |
| prot_lvl | input | 2 | Protect level from the status register |
| grant | output | 1 | One-cycle pulse: request accepted |
| reject | output | 1 | One-cycle pulse: request refused |
| hit_sector | output | 2 | Sector affected by the granted request |
| hit_page | output | 9 | Page affected by the granted program |
| rd_addr | input | 17 | Read address into the behavioural array |
| rd_data | output | 8 | Modelled byte at `rd_addr` |

## Verification
The bench builds the block with its default parameters: 17 address bits, two sector bits, 8-bit page offset and a 4-bit modelled offset. Those defaults give four sectors with 16 modelled bytes each, so the bench can read back all 64 cells after every request.

With exactly four sectors, each protect level locks a distinct set of sectors, so every level/sector pairing can be driven and every lock boundary tested. The small model also lets repeated programs to one cell expose AND accumulation, and a sector erase can be shown to leave its neighbours alone.

// File: rtl/flash_wg_pkg.sv
package flash_wg_pkg;
   typedef enum logic [1:0] {
      OP_IDLE   = 2'b00,
      OP_PROG   = 2'b01,
      OP_SERASE = 2'b10,
      OP_CHIP   = 2'b11
   } wg_op_e;
endpackage

// File: rtl/wg_lock_map.sv
module wg_lock_map #(
   parameter int SECT_W = 2
) (
   input  logic [1:0]              prot_lvl,
   output logic [(1<<SECT_W)-1:0]  locked
);
   localparam int NSECT = 1 << SECT_W;
   localparam int CW    = SECT_W + 2;

   logic [CW-1:0] lock_cnt;

   always_comb begin
      case (prot_lvl)
         2'b00:   lock_cnt = '0;
         2'b01:   lock_cnt = CW'(NSECT / 4);
         2'b10:   lock_cnt = CW'(NSECT / 2);
         default: lock_cnt = CW'(NSECT);
      endcase
   end

   for (genvar s = 0; s < NSECT; s++) begin : g_sect
      localparam logic [CW-1:0] SIDX = CW'(s);
      assign locked[s] = (SIDX + lock_cnt) >= CW'(NSECT);
   end
endmodule

// File: rtl/wg_decide.sv
module wg_decide
   import flash_wg_pkg::*;
#(
   parameter int SECT_W = 2
) (
   input  logic                    req_valid,
   input  wg_op_e                  op,
   input  logic [SECT_W-1:0]       sect,
   input  logic [(1<<SECT_W)-1:0]  locked,
   output logic                    accept,
   output logic                    refuse
);
   logic sector_op;
   logic sect_open;
   logic chip_open;

   assign sector_op = (op == OP_PROG) || (op == OP_SERASE);
   assign sect_open = !locked[sect];
   assign chip_open = (locked == '0);

   always_comb begin
      accept = 1'b0;
      refuse = 1'b0;
      if (req_valid && op != OP_IDLE) begin
         if (sector_op) accept = sect_open;
         else           accept = chip_open;
         refuse = !accept;
      end
   end
endmodule

// File: rtl/wg_cell_array.sv
module wg_cell_array #(
   parameter int SECT_W = 2,
   parameter int OFS_W  = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              do_prog,
   input  logic              do_serase,
   input  logic              do_chip,
   input  logic [SECT_W-1:0] wr_sect,
   input  logic [OFS_W-1:0]  wr_ofs,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SECT_W-1:0] rd_sect,
   input  logic [OFS_W-1:0]  rd_ofs,
   output logic [DATA_W-1:0] rd_data
);
   localparam int NSECT = 1 << SECT_W;
   localparam int NOFS  = 1 << OFS_W;

   logic [DATA_W-1:0] cells [NSECT][NOFS];

   for (genvar s = 0; s < NSECT; s++) begin : g_sect
      logic hit;
      assign hit = (wr_sect == SECT_W'(s));
      for (genvar o = 0; o < NOFS; o++) begin : g_cell
         always_ff @(posedge clk) begin
            if (!rst_n)
               cells[s][o] <= '1;
            else if (do_chip || (do_serase && hit))
               cells[s][o] <= '1;
            else if (do_prog && hit && wr_ofs == OFS_W'(o))
               cells[s][o] <= cells[s][o] & wr_data;
         end
      end
   end

   assign rd_data = cells[rd_sect][rd_ofs];
endmodule

// File: rtl/flash_wguard.sv
module flash_wguard
   import flash_wg_pkg::*;
#(
   parameter int ADDR_W      = 17,
   parameter int SECT_W      = 2,
   parameter int PAGE_W      = 8,
   parameter int MODEL_OFS_W = 4,
   parameter int DATA_W      = 8,
   localparam int PG_IDX_W   = ADDR_W - PAGE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [1:0]          req_cmd,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_data,
   input  logic [1:0]          prot_lvl,
   output logic                grant,
   output logic                reject,
   output logic [SECT_W-1:0]   hit_sector,
   output logic [PG_IDX_W-1:0] hit_page,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [DATA_W-1:0]   rd_data
);
   localparam int NSECT = 1 << SECT_W;

   if (SECT_W < 2) begin : g_bad_sect
      $error("flash_wguard: SECT_W must be at least 2");
   end
   if (PAGE_W + SECT_W > ADDR_W) begin : g_bad_page
      $error("flash_wguard: page offset overlaps sector field");
   end
   if (MODEL_OFS_W > ADDR_W - SECT_W) begin : g_bad_model
      $error("flash_wguard: modelled offset wider than a sector");
   end

   wg_op_e              op;
   logic [SECT_W-1:0]   req_sect;
   logic [NSECT-1:0]    locked;
   logic                accept;
   logic                refuse;

   assign op       = wg_op_e'(req_cmd);
   assign req_sect = req_addr[ADDR_W-1 -: SECT_W];

   wg_lock_map #(.SECT_W(SECT_W)) u_map (
      .prot_lvl (prot_lvl),
      .locked   (locked)
   );

   wg_decide #(.SECT_W(SECT_W)) u_dec (
      .req_valid (req_valid),
      .op        (op),
      .sect      (req_sect),
      .locked    (locked),
      .accept    (accept),
      .refuse    (refuse)
   );

   wg_cell_array #(
      .SECT_W (SECT_W),
      .OFS_W  (MODEL_OFS_W),
      .DATA_W (DATA_W)
   ) u_cells (
      .clk       (clk),
      .rst_n     (rst_n),
      .do_prog   (accept && op == OP_PROG),
      .do_serase (accept && op == OP_SERASE),
      .do_chip   (accept && op == OP_CHIP),
      .wr_sect   (req_sect),
      .wr_ofs    (req_addr[MODEL_OFS_W-1:0]),
      .wr_data   (req_data),
      .rd_sect   (rd_addr[ADDR_W-1 -: SECT_W]),
      .rd_ofs    (rd_addr[MODEL_OFS_W-1:0]),
      .rd_data   (rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant      <= 1'b0;
         reject     <= 1'b0;
         hit_sector <= '0;
         hit_page   <= '0;
      end else begin
         grant      <= accept;
         reject     <= refuse;
         hit_sector <= (accept && op != OP_CHIP) ? req_sect : '0;
         hit_page   <= (accept && op == OP_PROG) ? req_addr[ADDR_W-1:PAGE_W] : '0;
      end
   end

   logic unused_addr_bits;
   assign unused_addr_bits = ^{req_addr, rd_addr};
endmodule

// File: rtl/flash_wguard_chk.sv
module flash_wguard_chk #(
   parameter int ADDR_W = 17,
   parameter int SECT_W = 2,
   parameter int PAGE_W = 8,
   localparam int PG_IDX_W = ADDR_W - PAGE_W
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic [1:0]          req_cmd,
   input logic [ADDR_W-1:0]   req_addr,
   input logic [1:0]          prot_lvl,
   input logic                grant,
   input logic                reject,
   input logic [SECT_W-1:0]   hit_sector,
   input logic [PG_IDX_W-1:0] hit_page
);
   localparam logic [SECT_W-1:0] TOP_SECT = '1;

   logic sect_cmd;
   assign sect_cmd = req_valid && (req_cmd == 2'b01 || req_cmd == 2'b10);

   assert_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sect_cmd && prot_lvl == 2'b00) |=> grant);

   assert_top_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sect_cmd && prot_lvl == 2'b01 && req_addr[ADDR_W-1 -: SECT_W] == TOP_SECT) |=> reject);

   assert_all_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_cmd != 2'b00 && prot_lvl == 2'b11) |=> (reject && !grant));

   assert_chip_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_cmd == 2'b11 && prot_lvl != 2'b00) |=> reject);

   assert_page_report_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_cmd == 2'b01) |=>
         (!grant || hit_page == $past(req_addr[ADDR_W-1:PAGE_W])));

   assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant && reject));

   assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid || req_cmd == 2'b00) |=> (!grant && !reject && hit_sector == '0));
endmodule

bind flash_wguard flash_wguard_chk #(
   .ADDR_W (ADDR_W),
   .SECT_W (SECT_W),
   .PAGE_W (PAGE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_cmd    (req_cmd),
   .req_addr   (req_addr),
   .prot_lvl   (prot_lvl),
   .grant      (grant),
   .reject     (reject),
   .hit_sector (hit_sector),
   .hit_page   (hit_page)
);

// File: tb/flash_wguard_test.sv
`timescale 1ns/1ps
module flash_wguard_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_cmd = 2'b00;
   logic [16:0] req_addr = '0;
   logic [7:0]  req_data = '0;
   logic [1:0]  prot_lvl = 2'b00;
   logic        grant, reject;
   logic [1:0]  hit_sector;
   logic [8:0]  hit_page;
   logic [16:0] rd_addr = '0;
   logic [7:0]  rd_data;

   int checks = 0;
   int fails  = 0;
   logic [7:0] ref_mem [64];

   always #2.5 clk = ~clk;

   flash_wguard uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
      .req_addr(req_addr), .req_data(req_data), .prot_lvl(prot_lvl),
      .grant(grant), .reject(reject), .hit_sector(hit_sector),
      .hit_page(hit_page), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic bit is_locked(int s, int p);
      case (p)
         0: return 1'b0;
         1: return s == 3;
         2: return s >= 2;
         default: return 1'b1;
      endcase
   endfunction

   function automatic int cell_idx(logic [16:0] a);
      return {a[16:15], a[3:0]};
   endfunction

   task automatic check_cells(input string tag);
      int bad = -1;
      for (int i = 0; i < 64; i++) begin
         rd_addr = {i[5:4], 11'b0, i[3:0]};
         #0.01;
         if (rd_data !== ref_mem[i] && bad < 0) bad = i;
      end
      if (bad < 0) chk(1'b1, tag, 0, 0);
      else begin
         rd_addr = {bad[5:4], 11'b0, bad[3:0]};
         #0.01;
         chk(1'b0, $sformatf("%s cell %0d", tag, bad), rd_data, ref_mem[bad]);
      end
   endtask

   // one clock: drive after negedge, sample 1 ns after posedge
   task automatic step(input logic v, input logic [1:0] c, input logic [16:0] a,
                       input logic [7:0] d, input logic [1:0] p, input string tag);
      bit acc, rej;
      int s = a[16:15];
      acc = 1'b0; rej = 1'b0;
      if (v && c != 2'b00) begin
         if (c == 2'b11) acc = (p == 2'b00);
         else            acc = !is_locked(s, p);
         rej = !acc;
      end
      req_valid = v; req_cmd = c; req_addr = a; req_data = d; prot_lvl = p;
      @(posedge clk);
      #1;
      if (acc) begin
         if (c == 2'b01) ref_mem[cell_idx(a)] = ref_mem[cell_idx(a)] & d;
         else if (c == 2'b10) for (int o = 0; o < 16; o++) ref_mem[s*16+o] = 8'hFF;
         else for (int i = 0; i < 64; i++) ref_mem[i] = 8'hFF;
      end
      chk(grant == acc,  {tag, " grant"},  grant,  acc);
      chk(reject == rej, {tag, " reject"}, reject, rej);
      chk(hit_sector == ((acc && c != 2'b11) ? s : 0), {tag, " R7 sector"},
          hit_sector, (acc && c != 2'b11) ? s : 0);
      chk(hit_page == ((acc && c == 2'b01) ? int'(a[16:8]) : 0), {tag, " R7 page"},
          hit_page, (acc && c == 2'b01) ? int'(a[16:8]) : 0);
      check_cells({tag, " cells"});
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 64; i++) ref_mem[i] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk(!grant && !reject, "R1 handshake idle", {grant, reject}, 0);
      chk(hit_sector == 0 && hit_page == 0, "R1 hit fields", {hit_sector, hit_page}, 0);
      check_cells("R1 erased after reset");
      @(negedge clk);

      // R2 / R8: open level, repeated program accumulates by AND
      step(1, 2'b01, 17'h00003, 8'hA5, 2'b00, "R2 prog s0");
      step(1, 2'b01, 17'h00003, 8'h3C, 2'b00, "R8 reprogram AND");
      step(1, 2'b01, 17'h00003, 8'hFF, 2'b00, "R8 ones cannot set");
      step(1, 2'b01, 17'h18005, 8'h0F, 2'b00, "R2 prog s3");
      step(1, 2'b01, 17'h0A10E, 8'h81, 2'b00, "R2 prog s1");
      step(1, 2'b01, 17'h1320B, 8'h55, 2'b00, "R2 prog s2");

      // R3: level 1
      step(1, 2'b01, 17'h18001, 8'h00, 2'b01, "R3 prog s3 locked");
      step(0, 2'b00, 17'h0,     8'h00, 2'b01, "R10 reject one cycle");
      step(1, 2'b10, 17'h1FFFF, 8'h00, 2'b01, "R3 erase s3 locked");
      step(1, 2'b01, 17'h10002, 8'h70, 2'b01, "R3 prog s2 open");
      step(1, 2'b11, 17'h0,     8'h00, 2'b01, "R6 chip at level1");

      // R4: level 2
      step(1, 2'b01, 17'h10004, 8'h00, 2'b10, "R4 prog s2 locked");
      step(1, 2'b10, 17'h10000, 8'h00, 2'b10, "R4 erase s2 locked");
      step(1, 2'b01, 17'h0FFF7, 8'hC3, 2'b10, "R4 prog s1 open");
      step(1, 2'b11, 17'h0,     8'h00, 2'b10, "R6 chip at level2");

      // R5: level 3
      step(1, 2'b01, 17'h00001, 8'h00, 2'b11, "R5 prog s0 locked");
      step(1, 2'b10, 17'h00000, 8'h00, 2'b11, "R5 erase s0 locked");
      step(1, 2'b11, 17'h0,     8'h00, 2'b11, "R5 chip locked");

      // full level/sector sweep (R2 R3 R4 R5 R10)
      for (int p = 0; p < 4; p++)
         for (int s = 0; s < 4; s++)
            step(1, 2'b01, {s[1:0], 7'h2B, 4'(s + p), 4'(p + 3)}, 8'(8'hF7 - 8'(s*16 + p)),
                 p[1:0], $sformatf("R3 R4 R5 sweep lvl%0d s%0d", p, s));

      // R11: idle command, and a request with valid low
      step(1, 2'b00, 17'h00003, 8'h00, 2'b00, "R11 idle cmd");
      step(0, 2'b01, 17'h00003, 8'h00, 2'b00, "R11 valid low");
      step(0, 2'b11, 17'h0,     8'h00, 2'b00, "R11 chip valid low");

      // R9: sector erase then chip erase
      step(1, 2'b10, 17'h0ABCD, 8'h00, 2'b00, "R9 erase s1 only");
      step(1, 2'b01, 17'h18009, 8'h12, 2'b00, "R9 prog before chip");
      step(1, 2'b11, 17'h12345, 8'h00, 2'b00, "R6 R9 chip erase open");
      step(0, 2'b00, 17'h0,     8'h00, 2'b00, "R10 quiet after grant");

      finish_run();
   end
endmodule